// File: doc/BRIEF.md
# Character-Row Raster Timing Sequencer

This block produces the raster timing for a character-cell text display. A clock enable marks each process cycle. A fixed-length line counter runs on that enable and produces an active-low horizontal sync pulse and a horizontal blanking window near the end of each line. Each completed line steps a glyph scanline counter. Each wrap of the scanline counter steps a text-row counter, and the row and scanline values together decide vertical blanking and vertical sync.

Downstream stages use the scanline index, the row index and one combined blank flag to fetch and draw glyphs. Pixel shifting, font lookup and memory access sit outside this block. All outputs are registered, so every sync and blank edge, and every counter step, lands on the same clock edge. With the default parameters a line lasts 208 enabled cycles and a field holds 640 lines, which gives a 60 Hz field at a 38.4 kHz line rate.

Top module: `raster_seq`

## Requirements
- R1: A synchronous reset takes priority over the enable. On the edge after reset, `scan` = 0, `row` = 0, `hsync_n` = 1, `blank` = 0 and `vsync` = 0, and the line position restarts at 0.
- R2: In a cycle where `ce` is low, no counter advances and `scan`, `row`, `hsync_n`, `blank` and `vsync` all keep their values.
- R3: A line lasts exactly 208 enabled cycles, positions 0 to 207 counted from the line start. `hsync_n` is 0 for positions 176 to 199: a 24-cycle pulse that ends 8 positions before the line end. It is 1 at all other positions.
- R4: `blank` is 1 for line positions 160 to 207 in every line (horizontal blanking).
- R5: `scan` counts 0 to 7 and steps at each line end. When it passes 7 it returns to 0, and `row` increments on the same edge.
- R6: `row` counts 0 to 79. At the end of the last line of row 79, `row` and `scan` both return to 0, so a field is 640 lines, and the vertical blank and sync state clears.
- R7: Rows 0 to 75 are active. For rows 76 to 79, `blank` is 1 at every line position.
- R8: `vsync` is 1 exactly for scanlines 0 to 3 of row 76. It rises on the same edge that first raises vertical blank and falls when the scanline moves from 3 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Process-cycle enable; one pulse advances the line position by one |
| scan | output | 3 | Glyph scanline index within the current text row |
| row | output | 7 | Text-row index within the field |
| hsync_n | output | 1 | Horizontal sync, active low |
| blank | output | 1 | Combined horizontal and vertical blanking |
| vsync | output | 1 | Vertical sync, active high |

## Verification
Several functions meet on one edge, and these cases get the closest checking. The line wrap of the last line of row 75 steps the scanline and row counters, raises vertical blank and raises vertical sync all at once. At the same moment horizontal blanking ends while `blank` must stay high. The bench drives the enable up to that exact line boundary and compares every output against values derived from the enable count. It repeats this at the scanline 3-to-4 step and at the field wrap, and it also applies reset in a cycle where the enable is high.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;

    typedef struct packed {
        logic hsync_n;
        logic blank;
        logic vsync;
    } sync_flags_t;

    localparam sync_flags_t FLAGS_IDLE = '{hsync_n: 1'b1, blank: 1'b0, vsync: 1'b0};

endpackage

// File: rtl/raster_line_timer.sv
module raster_line_timer #(
    parameter int LINE_CYCLES   = 208,
    parameter int HSYNC_WIDTH   = 24,
    parameter int HSYNC_GAP     = 8,
    parameter int HBLANK_CYCLES = 48,
    localparam int H_W          = $clog2(LINE_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic line_end,
    output logic hsync_d,
    output logic hblank_d
);

    localparam logic [H_W-1:0] H_LAST     = H_W'(LINE_CYCLES - 1);
    localparam logic [H_W-1:0] HS_FIRST   = H_W'(LINE_CYCLES - HSYNC_GAP - HSYNC_WIDTH);
    localparam logic [H_W-1:0] HS_LAST    = H_W'(LINE_CYCLES - HSYNC_GAP - 1);
    localparam logic [H_W-1:0] HB_FIRST   = H_W'(LINE_CYCLES - HBLANK_CYCLES);

    logic [H_W-1:0] pos_d, pos_q;

    always_comb begin
        line_end = ce && (pos_q == H_LAST);
        pos_d    = pos_q;
        if (ce) begin
            pos_d = line_end ? '0 : pos_q + 1'b1;
        end
        if (rst) begin
            pos_d = '0;
        end
        // decode on the next position so the registered flags align with it
        hsync_d  = (pos_d >= HS_FIRST) && (pos_d <= HS_LAST);
        hblank_d = (pos_d >= HB_FIRST);
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

endmodule

// File: rtl/raster_frame_counter.sv
module raster_frame_counter #(
    parameter int SCAN_LINES  = 8,
    parameter int ROWS        = 80,
    parameter int ACTIVE_ROWS = 76,
    parameter int VSYNC_SCANS = 4,
    localparam int SCAN_W     = $clog2(SCAN_LINES),
    localparam int ROW_W      = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    output logic [SCAN_W-1:0] scan_q,
    output logic [ROW_W-1:0]  row_q,
    output logic              vblank_d,
    output logic              vsync_d
);

    localparam logic [SCAN_W-1:0] SCAN_LAST  = SCAN_W'(SCAN_LINES - 1);
    localparam logic [SCAN_W-1:0] VS_LAST    = SCAN_W'(VSYNC_SCANS - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST   = ROW_W'(ROWS - 1);
    localparam logic [ROW_W-1:0]  ROW_VBLANK = ROW_W'(ACTIVE_ROWS);

    logic [SCAN_W-1:0] scan_d;
    logic [ROW_W-1:0]  row_d;

    always_comb begin
        scan_d = scan_q;
        row_d  = row_q;
        if (line_end) begin
            if (scan_q == SCAN_LAST) begin
                scan_d = '0;
                row_d  = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                scan_d = scan_q + 1'b1;
            end
        end
        if (rst) begin
            scan_d = '0;
            row_d  = '0;
        end
        vblank_d = (row_d >= ROW_VBLANK);
        vsync_d  = (row_d == ROW_VBLANK) && (scan_d <= VS_LAST);
    end

    always_ff @(posedge clk) begin
        scan_q <= scan_d;
        row_q  <= row_d;
    end

endmodule

// File: rtl/raster_seq.sv
module raster_seq
    import raster_seq_pkg::*;
#(
    parameter int LINE_CYCLES   = 208,
    parameter int HSYNC_WIDTH   = 24,
    parameter int HSYNC_GAP     = 8,
    parameter int HBLANK_CYCLES = 48,
    parameter int SCAN_LINES    = 8,
    parameter int ROWS          = 80,
    parameter int ACTIVE_ROWS   = 76,
    parameter int VSYNC_SCANS   = 4,
    localparam int SCAN_W       = $clog2(SCAN_LINES),
    localparam int ROW_W        = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    output logic [SCAN_W-1:0] scan,
    output logic [ROW_W-1:0]  row,
    output logic              hsync_n,
    output logic              blank,
    output logic              vsync
);

    logic        line_end;
    logic        hsync_d, hblank_d;
    logic        vblank_d, vsync_d;
    sync_flags_t flags_d, flags_q;

    raster_line_timer #(
        .LINE_CYCLES  (LINE_CYCLES),
        .HSYNC_WIDTH  (HSYNC_WIDTH),
        .HSYNC_GAP    (HSYNC_GAP),
        .HBLANK_CYCLES(HBLANK_CYCLES)
    ) i_line (
        .clk     (clk),
        .rst     (rst),
        .ce      (ce),
        .line_end(line_end),
        .hsync_d (hsync_d),
        .hblank_d(hblank_d)
    );

    raster_frame_counter #(
        .SCAN_LINES (SCAN_LINES),
        .ROWS       (ROWS),
        .ACTIVE_ROWS(ACTIVE_ROWS),
        .VSYNC_SCANS(VSYNC_SCANS)
    ) i_frame (
        .clk     (clk),
        .rst     (rst),
        .line_end(line_end),
        .scan_q  (scan),
        .row_q   (row),
        .vblank_d(vblank_d),
        .vsync_d (vsync_d)
    );

    always_comb begin
        flags_d.hsync_n = !hsync_d;
        flags_d.blank   = hblank_d || vblank_d;
        flags_d.vsync   = vsync_d;
        if (rst) begin
            flags_d = FLAGS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign hsync_n = flags_q.hsync_n;
    assign blank   = flags_q.blank;
    assign vsync   = flags_q.vsync;

endmodule

// File: rtl/raster_seq_chk.sv
module raster_seq_chk #(
    parameter int SCAN_LINES  = 8,
    parameter int ROWS        = 80,
    parameter int ACTIVE_ROWS = 76,
    localparam int SCAN_W     = $clog2(SCAN_LINES),
    localparam int ROW_W      = $clog2(ROWS)
) (
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic [SCAN_W-1:0] scan,
    input logic [ROW_W-1:0]  row,
    input logic              hsync_n,
    input logic              blank,
    input logic              vsync
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (scan == '0) && (row == '0) && hsync_n && !blank && !vsync);

    assert_hold_on_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(ce) && !$past(rst)) |-> ($stable(scan) && $stable(row) &&
            $stable(hsync_n) && $stable(blank) && $stable(vsync)));

    assert_scan_range_R5: assert property (@(posedge clk) disable iff (rst)
        int'(scan) < SCAN_LINES);

    assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(row) != row && !$past(rst)) |->
            (scan == '0) && (int'($past(scan)) == SCAN_LINES - 1));

    assert_row_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(row) < ROWS);

    assert_vblank_full_line_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(row) >= ACTIVE_ROWS) |-> blank);

    assert_vsync_in_blank_R8: assert property (@(posedge clk) disable iff (rst)
        vsync |-> (blank && int'(row) == ACTIVE_ROWS));

    assert_vsync_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (scan == '0) && $rose(int'(row) >= ACTIVE_ROWS));

endmodule

bind raster_seq raster_seq_chk #(
    .SCAN_LINES (SCAN_LINES),
    .ROWS       (ROWS),
    .ACTIVE_ROWS(ACTIVE_ROWS)
) i_raster_seq_chk (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .scan   (scan),
    .row    (row),
    .hsync_n(hsync_n),
    .blank  (blank),
    .vsync  (vsync)
);

// File: tb/test_raster_seq.sv
module test_raster_seq;

    localparam int LINE  = 208;
    localparam int FIELD = 640;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b0;
    logic [2:0] scan;
    logic [6:0] row;
    logic       hsync_n, blank, vsync;

    int n      = 0;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    raster_seq i_raster_seq (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .scan   (scan),
        .row    (row),
        .hsync_n(hsync_n),
        .blank  (blank),
        .vsync  (vsync)
    );

    // one clock; inputs change 2 ns after the edge, results sampled there too
    task automatic tick(input logic c);
        ce = c;
        @(posedge clk);
        #2;
        if (c && !rst) n++;
    endtask

    task automatic advance_to(input int target);
        while (n < target) tick(1'b1);
    endtask

    task automatic check(input string req);
        int h, line, s, r;
        logic [12:0] exp_v, act_v;
        h     = n % LINE;
        line  = (n / LINE) % FIELD;
        s     = line % 8;
        r     = line / 8;
        exp_v = {3'(s), 7'(r), !(h >= 176 && h <= 199), (h >= 160) || (r >= 76),
                 (r == 76) && (s <= 3)};
        act_v = {scan, row, hsync_n, blank, vsync};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s at count %0d: scan/row/hs_n/blank/vs actual %0d/%0d/%b/%b/%b expected %0d/%0d/%b/%b/%b",
                     req, n, act_v[12:10], act_v[9:3], act_v[2], act_v[1], act_v[0],
                     exp_v[12:10], exp_v[9:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic t_reset_R1;
        rst = 1'b1;
        repeat (4) tick(1'b0);
        rst = 1'b0;
        n   = 0;
        check("R1");
    endtask

    task automatic t_line_R3_R4;
        advance_to(159); check("R4");
        advance_to(160); check("R4");
        advance_to(175); check("R3");
        advance_to(176); check("R3");
        advance_to(199); check("R3");
        advance_to(200); check("R3");
        advance_to(207); check("R4");
        advance_to(208); check("R3");
    endtask

    task automatic t_idle_R2;
        advance_to(LINE + 175);
        for (int i = 0; i < 6; i++) begin
            tick(1'b0);
            check("R2");
        end
        for (int i = 0; i < 8; i++) begin
            tick(i[0]);
            check("R2");
        end
    endtask

    task automatic t_scan_R5;
        advance_to(LINE * 3);     check("R5");
        advance_to(LINE * 8 - 1); check("R5");
        advance_to(LINE * 8);     check("R5");
        advance_to(LINE * 9);     check("R5");
    endtask

    task automatic t_vblank_R7_R8;
        advance_to(LINE * 608 - 60); check("R7");
        advance_to(LINE * 608 - 1);  check("R7");
        advance_to(LINE * 608);      check("R8");
        advance_to(LINE * 608 + 5);  check("R7");
        advance_to(LINE * 612 - 1);  check("R8");
        advance_to(LINE * 612);      check("R8");
        advance_to(LINE * 616 + 20); check("R7");
    endtask

    task automatic t_wrap_R6;
        advance_to(LINE * FIELD - 1); check("R6");
        advance_to(LINE * FIELD);     check("R6");
        advance_to(LINE * FIELD + 1); check("R6");
    endtask

    task automatic t_reset_with_ce_R1;
        advance_to(LINE * FIELD + LINE * 9 + 170);
        rst = 1'b1;
        tick(1'b1);
        rst = 1'b0;
        n   = 0;
        check("R1");
        tick(1'b1);
        check("R1");
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog: actual run still going, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_line_R3_R4();
        t_idle_R2();
        t_scan_R5();
        t_vblank_R7_R8();
        t_wrap_R6();
        t_reset_with_ce_R1();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule